// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block decides which of seven pending interrupt requests a processor core should take next. The sources are external line 0, timer 0, external line 1, the watchdog, timer 1, serial channel 0 and timer 2. They fall into six priority groups. The watchdog shares its group with external line 1, so both always have the same level. Each group gets a 2-bit level from two 6-bit registers. One register holds the low bit of every group's level and the other holds the high bit.

The block presents one granted request as a valid flag, a 3-bit source index and the granted level. The grant stays put until the core acknowledges it or the request goes away. On an acknowledge, the block marks the granted level as in service. From then on only a strictly higher level can interrupt. A return-from-interrupt pulse retires the highest level in service. The watchdog request is held in a flag register. Watchdog hardware sets the flag and software clears it through the register port.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, both level registers and the flag register read 0x00, no grant is presented and no level is in service.
- R2: The level of group g is {hi[g], lo[g]}. lo is the register at address 0xA9 and hi is the register at 0xB9, each using bits 5..0. Bits 7..6 read 0 and ignore writes. Level 3 is the highest and level 0 the lowest.
- R3: Sources are indexed 0 ext0, 1 tmr0, 2 ext1, 3 watchdog, 4 tmr1, 5 ser0, 6 tmr2. Their groups are 0, 1, 2, 2, 3, 4 and 5 respectively.
- R4: The watchdog request is bit 1 of the flag register at 0x97, and all other bits of that register read 0. A software write sets that bit to wdata[1]. A hardware set in the same cycle wins over the write.
- R5: Among the eligible pending requests, the one with the highest level is granted.
- R6: Among eligible requests of equal level, the lowest source index is granted. This means ext1 wins over the watchdog.
- R7: A request is eligible only when nothing is in service or its level is strictly above the highest level in service.
- R8: An acknowledge while a grant is valid marks the granted level in service and removes the grant. A return pulse clears the highest in-service level.
- R9: A grant appears one cycle after an eligible request is seen. It is held, with the same source and level, until it is acknowledged or its request drops.
- R10: Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 6 | Pending requests: bits 0..5 = ext0, tmr0, ext1, tmr1, ser0, tmr2 |
| wdt_set | input | 1 | Watchdog hardware sets its flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Core takes the presented grant |
| irq_reti | input | 1 | Core returns from the current handler |
| irq_valid | output | 1 | A grant is presented |
| irq_src | output | 3 | Granted source index |
| irq_level | output | 2 | Level of the granted source |

## Verification
The central sweep runs each of sixteen level configurations against every one of the 128 request patterns. The configurations include all-equal levels, which isolate the polling order, and mixed levels, which check that level outranks position. Patterns with both ext1 and the watchdog pending show that the two share one level and that ext1 wins. A directed nesting sequence acknowledges and returns across two levels. It shows that a request at or below the in-service level is held back and is released only when the matching return arrives. Register probes cover the unused bits, an unmapped address, and a software clear colliding with a hardware set.

// File: rtl/irq_prio_pkg.sv
// Shared constants, types and the source-to-group map for the interrupt
// priority controller. Assumes seven sources in fixed polling order.
package irq_prio_pkg;
    localparam int NUM_SRC = 7;
    localparam int NUM_GRP = 6;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [SRC_W-1:0] src_t;

    // Group of each source: the watchdog (index 3) rides in group 2.
    function automatic int unsigned src_group(input int unsigned s);
        if (s < 3)       return s;
        else if (s == 3) return 2;
        else             return s - 1;
    endfunction
endpackage

// File: rtl/irq_prio_regs.sv
// Register port: low and high level-bit registers plus the watchdog flag
// register. Unused bits read 0; a hardware flag set beats a software write.
module irq_prio_regs #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter int          NUM_GRP  = 6,
    parameter logic [7:0]  LO_ADDR  = 8'hA9,
    parameter logic [7:0]  HI_ADDR  = 8'hB9,
    parameter logic [7:0]  FLG_ADDR = 8'h97,
    parameter int          FLG_BIT  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               wdt_set,
    output logic [NUM_GRP-1:0] lvl_lo,
    output logic [NUM_GRP-1:0] lvl_hi,
    output logic               wdt_flag
);
    localparam int PAD_W = DATA_W - NUM_GRP;

    logic sel_lo, sel_hi, sel_flg;

    // Decode which register the address selects.
    always_comb begin
        sel_lo  = (addr == ADDR_W'(LO_ADDR));
        sel_hi  = (addr == ADDR_W'(HI_ADDR));
        sel_flg = (addr == ADDR_W'(FLG_ADDR));
    end

    // Level-bit registers: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_lo <= '0;
            lvl_hi <= '0;
        end else if (wr) begin
            if (sel_lo) lvl_lo <= wdata[NUM_GRP-1:0];
            if (sel_hi) lvl_hi <= wdata[NUM_GRP-1:0];
        end
    end

    // Watchdog flag: hardware set has precedence over software write.
    always_ff @(posedge clk) begin
        if (!rst_n)              wdt_flag <= 1'b0;
        else if (wdt_set)        wdt_flag <= 1'b1;
        else if (wr && sel_flg)  wdt_flag <= wdata[FLG_BIT];
    end

    // Read mux with zero fill for unused bits and unmapped addresses.
    always_comb begin
        rdata = '0;
        if (sel_lo)       rdata = {{PAD_W{1'b0}}, lvl_lo};
        else if (sel_hi)  rdata = {{PAD_W{1'b0}}, lvl_hi};
        else if (sel_flg) rdata[FLG_BIT] = wdt_flag;
    end

    // R4: a hardware set always leaves the flag raised.
    a_r4_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_set |=> wdt_flag);
    // R4: a software write of 0 without a hardware set clears the flag.
    a_r4_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel_flg && !wdata[FLG_BIT] && !wdt_set) |=> !wdt_flag);
    // R10: a write elsewhere leaves the level registers unchanged.
    a_r10_no_side_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel_lo && !sel_hi) |=> ($stable(lvl_lo) && $stable(lvl_hi)));
endmodule

// File: rtl/irq_pick.sv
// Combinational selector: maps each source to its group level, masks out
// requests not above the in-service level, then takes the highest level,
// lowest index winning ties. Assumes group levels are already assembled.
module irq_pick
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int N_GRP = NUM_GRP
) (
    input  lvl_t [N_GRP-1:0] grp_lvl,
    input  logic [N_SRC-1:0] pend,
    input  logic             busy,
    input  lvl_t             busy_lvl,
    output logic             pick_valid,
    output src_t             pick_src,
    output lvl_t             pick_lvl
);
    lvl_t [N_SRC-1:0] src_lvl;
    logic [N_SRC-1:0] elig;

    // Per-source level lookup and eligibility against the nesting floor.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        always_comb begin
            src_lvl[s] = grp_lvl[src_group(s)];
            elig[s]    = pend[s] && (!busy || (src_lvl[s] > busy_lvl));
        end
    end

    // Scan in polling order; only a strictly higher level displaces.
    always_comb begin
        pick_valid = 1'b0;
        pick_src   = '0;
        pick_lvl   = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (elig[s] && (!pick_valid || (src_lvl[s] > pick_lvl))) begin
                pick_valid = 1'b1;
                pick_src   = src_t'(s);
                pick_lvl   = src_lvl[s];
            end
        end
    end
endmodule

// File: rtl/irq_in_service.sv
// In-service tracker: one bit per level, set on acknowledge, highest set
// bit cleared on return. Reports whether any level is active and which.
module irq_in_service
    import irq_prio_pkg::*;
#(
    parameter int N_LVL = NUM_LVL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  lvl_t set_lvl,
    input  logic clr_top,
    output logic active,
    output lvl_t top_lvl
);
    logic [N_LVL-1:0] isr;
    logic [N_LVL-1:0] isr_nxt;

    // Highest level currently in service.
    always_comb begin
        active  = |isr;
        top_lvl = '0;
        for (int l = 0; l < N_LVL; l++)
            if (isr[l]) top_lvl = lvl_t'(l);
    end

    // Next state: return retires the top bit, then acknowledge adds one.
    always_comb begin
        isr_nxt = isr;
        if (clr_top && active) isr_nxt[top_lvl] = 1'b0;
        if (set_en)            isr_nxt[set_lvl] = 1'b1;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= isr_nxt;
    end

    // R8: acknowledge marks its level in service.
    a_r8_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> isr[$past(set_lvl)]);
    // R8: a lone return removes exactly one in-service level.
    a_r8_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top && active && !set_en) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/irq_level_arbiter.sv
// Top of the grouped four-level interrupt priority controller. Holds the
// granted request until acknowledged or withdrawn; assumes the core pulses
// ack and reti for one cycle each.
module irq_level_arbiter
    import irq_prio_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] LO_ADDR  = 8'hA9,
    parameter logic [7:0] HI_ADDR  = 8'hB9,
    parameter logic [7:0] FLG_ADDR = 8'h97,
    parameter int         FLG_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        src_req,
    input  logic              wdt_set,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_ack,
    input  logic              irq_reti,
    output logic              irq_valid,
    output logic [2:0]        irq_src,
    output logic [1:0]        irq_level
);
    logic [NUM_GRP-1:0] lvl_lo, lvl_hi;
    logic               wdt_flag;
    lvl_t [NUM_GRP-1:0] grp_lvl;
    logic [NUM_SRC-1:0] pend;
    logic               busy;
    lvl_t               busy_lvl;
    logic               pick_valid;
    src_t               pick_src;
    lvl_t               pick_lvl;
    logic               take;
    logic               held_pend;

    irq_prio_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GRP(NUM_GRP),
        .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .FLG_ADDR(FLG_ADDR), .FLG_BIT(FLG_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .wdt_set(wdt_set),
        .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .wdt_flag(wdt_flag)
    );

    // Assemble group levels and the request vector in polling order.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_lvl[g] = {lvl_hi[g], lvl_lo[g]};
    end
    assign pend = {src_req[5:3], wdt_flag, src_req[2:0]};

    irq_pick #(.N_SRC(NUM_SRC), .N_GRP(NUM_GRP)) u_pick (
        .grp_lvl(grp_lvl), .pend(pend), .busy(busy), .busy_lvl(busy_lvl),
        .pick_valid(pick_valid), .pick_src(pick_src), .pick_lvl(pick_lvl)
    );

    // Acknowledge only counts while a grant is presented.
    always_comb begin
        take      = irq_ack && irq_valid;
        held_pend = pend[irq_src];
    end

    irq_in_service #(.N_LVL(NUM_LVL)) u_isr (
        .clk(clk), .rst_n(rst_n), .set_en(take), .set_lvl(irq_level),
        .clr_top(irq_reti), .active(busy), .top_lvl(busy_lvl)
    );

    // Grant register: load when idle, hold until taken or withdrawn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_src   <= '0;
            irq_level <= '0;
        end else if (irq_valid) begin
            if (take || !held_pend) irq_valid <= 1'b0;
        end else if (pick_valid) begin
            irq_valid <= 1'b1;
            irq_src   <= pick_src;
            irq_level <= pick_lvl;
        end
    end

    // R9: a grant neither taken nor withdrawn stays identical.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack && held_pend) |=>
        (irq_valid && $stable(irq_src) && $stable(irq_level)));
    // R7: a presented grant is always above the in-service level.
    a_r7_nest_above: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (!busy || (irq_level > busy_lvl)));
    // R8: an acknowledged grant is removed in the next cycle.
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !irq_valid);
    // R3: the granted source index is always one of the seven sources.
    a_r3_src_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_src < 3'(NUM_SRC)));
endmodule

// File: tb/test_irq_level_arbiter.sv
module test_irq_level_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_req = '0;
    logic       wdt_set = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_reti = 1'b0;
    logic       irq_valid;
    logic [2:0] irq_src;
    logic [1:0] irq_level;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_level_arbiter i_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .wdt_set(wdt_set),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_reti(irq_reti),
        .irq_valid(irq_valid), .irq_src(irq_src), .irq_level(irq_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic grant_chk(input bit v, input int s, input int l, input string req);
        chk(irq_valid == v, req, irq_valid, v);
        if (v) chk({irq_src, irq_level} == {3'(s), 2'(l)}, req, {irq_src, irq_level}, {3'(s), 2'(l)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        rd_chk(8'hA9, 8'h00, "R1 lo reset");
        rd_chk(8'hB9, 8'h00, "R1 hi reset");
        rd_chk(8'h97, 8'h00, "R1 flag reset");
        grant_chk(1'b0, 0, 0, "R1 no grant");

        // R2: unused bits of level registers
        wr_reg(8'hA9, 8'hFF);
        rd_chk(8'hA9, 8'h3F, "R2 lo unused bits");
        wr_reg(8'hB9, 8'hC5);
        rd_chk(8'hB9, 8'h05, "R2 hi unused bits");
        // R10: unmapped address
        wr_reg(8'h55, 8'hFF);
        rd_chk(8'h55, 8'h00, "R10 unmapped read");
        rd_chk(8'hA9, 8'h3F, "R10 lo untouched");
        rd_chk(8'hB9, 8'h05, "R10 hi untouched");
        // R4: flag register bits and hardware precedence
        wr_reg(8'h97, 8'hFF);
        rd_chk(8'h97, 8'h02, "R4 flag only bit1");
        wdt_set = 1'b1;
        wr_reg(8'h97, 8'h00);
        wdt_set = 1'b0;
        rd_chk(8'h97, 8'h02, "R4 hw set wins");
        wr_reg(8'h97, 8'h00);
        rd_chk(8'h97, 8'h00, "R4 sw clear");
        cyc();

        // R3 R5 R6: sweep of level configurations against all request patterns
        for (int c = 0; c < 16; c++) begin
            logic [5:0] lo, hi;
            lo = (c == 0) ? 6'h00 : (c == 1) ? 6'h3F : 6'((c * 13 + 5) & 63);
            hi = (c == 0) ? 6'h00 : (c == 1) ? 6'h3F : 6'((c * 29 + (c / 3) * 7) & 63);
            wr_reg(8'hA9, {2'b00, lo});
            wr_reg(8'hB9, {2'b00, hi});
            for (int p = 0; p < 128; p++) begin
                int best_s, best_l;
                src_req = '0;
                wr_reg(8'h97, 8'h00);
                cyc();
                wdt_set = p[3];
                cyc();
                wdt_set = 1'b0;
                src_req = {p[6:4], p[2:0]};
                cyc();
                best_s = -1; best_l = -1;
                for (int s = 0; s < 7; s++) begin
                    int g, l;
                    g = (s < 3) ? s : (s == 3) ? 2 : s - 1;
                    l = hi[g] * 2 + lo[g];
                    if (p[s] && l > best_l) begin
                        best_s = s; best_l = l;
                    end
                end
                grant_chk(p != 0, best_s, best_l, "R5 R6 R3 sweep");
            end
        end
        src_req = '0;
        wr_reg(8'h97, 8'h00);
        cyc();

        // R7 R8: nesting. ext0 at level 1, tmr0 at level 3.
        wr_reg(8'hA9, 8'h03);
        wr_reg(8'hB9, 8'h02);
        src_req = 6'b000001;
        cyc();
        grant_chk(1'b1, 0, 1, "R9 grant one cycle after request");
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        grant_chk(1'b0, 0, 0, "R8 ack removes grant");
        cyc();
        grant_chk(1'b0, 0, 0, "R7 same level blocked");
        src_req = 6'b000011;
        cyc();
        grant_chk(1'b1, 1, 3, "R7 higher level nests");
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        src_req = 6'b000001;
        cyc();
        grant_chk(1'b0, 0, 0, "R7 blocked under level 3");
        irq_reti = 1'b1; cyc(); irq_reti = 1'b0;
        cyc();
        grant_chk(1'b0, 0, 0, "R8 reti clears only top level");
        irq_reti = 1'b1; cyc(); irq_reti = 1'b0;
        cyc();
        grant_chk(1'b1, 0, 1, "R8 second reti releases ext0");

        // R9: hold against a higher arrival, then drop
        src_req = 6'b000011;
        cyc();
        grant_chk(1'b1, 0, 1, "R9 grant held");
        src_req = 6'b000010;
        cyc();
        grant_chk(1'b0, 0, 0, "R9 drop removes grant");
        cyc();
        grant_chk(1'b1, 1, 3, "R9 next grant after drop");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule